// File: doc/BRIEF.md
# Protection Fault Supervisor with Timed Auto-Restart

This block is the supervisor that decides whether a flyback power stage may switch. It gathers protection inputs: comparator flags for supply overvoltage, per-cycle fast output overvoltage and an emergency overcurrent stop, and digitised codes for the sensed output voltage, the rectified line voltage and die temperature. Each input has its own qualification rule. A fault can act at once, after a run of switching cycles, or after a number of millisecond ticks. The block drives one registered switching enable.

Faults that stop switching outright (supply overvoltage, confirmed fast overvoltage, output short, overcurrent stop) start a shared recovery wait of `REC_TICKS` millisecond ticks. Switching is retried after the wait. Level conditions (brown-out, line overvoltage, over-temperature) block switching only for as long as they last. Each has its own hysteresis and blanking. A separate slow-overvoltage flag asks the cycle sequencer to stretch the switching period. It does not stop switching. A cause register holds the first fault seen and clears when switching resumes. All timer lengths are parameters counted in ticks, so the default of 4000 ticks gives about 4 s.

Top module: `fault_supervisor`

## Requirements
- R1: A high `vcc_ovp` on a clock edge clears `sw_en` at that edge. `sw_en` then stays low until `REC_TICKS` `ms_tick` pulses have been seen after the last such edge. It returns high on the next clock after that, provided no other condition blocks it.
- R2: A fast overvoltage is confirmed when `fovp_hit` is high on `FOVP_CYCLES` consecutive `cyc_strobe` pulses while switching is enabled. A strobe with `fovp_hit` low restarts the count. Confirmation clears `sw_en` and starts the recovery wait.
- R3: An output short is confirmed when `vout_code` is below `VO_SHORT` on `SHORT_TICKS` consecutive `ms_tick` pulses while switching is enabled. A tick with the code at or above the threshold restarts the count. Confirmation clears `sw_en` and starts the recovery wait.
- R4: A high `ocp_stop` clears `sw_en` at that edge and starts the recovery wait.
- R5: Any stop fault that arrives during the recovery wait reloads the full `REC_TICKS` wait.
- R6: After reset, switching is blocked as a brown-out. The line is declared good once `vline_code > BO_ON` has held for `BLANK_TICKS` ticks. It is declared bad once `vline_code < BO_OFF` has held for `BLANK_TICKS` ticks. Between the two thresholds the state does not change.
- R7: `vline_code > LOVP_ON` sets line overvoltage at once, and `sw_en` is low two clocks later. It is released only after `vline_code < LOVP_OFF` has held for `BLANK_TICKS` ticks.
- R8: `temp_code >= TSD_ON` sets over-temperature, and `sw_en` is low two clocks later. Over-temperature is released only when `temp_code <= TSD_OFF`.
- R9: `slow_ovp` rises one clock after `vout_code >= VO_ENGAGE` and falls one clock after `vout_code <= VO_RELEASE`. Between the two it holds its value. It never changes `sw_en`.
- R10: `fault_cause` reads 0 after reset. It records the first fault with the code 1 supply OV, 2 fast OV, 3 short, 4 overcurrent, 5 brown-out, 6 line OV or 7 thermal, with the lowest code winning a tie. It holds that code until the edge at which `sw_en` rises, where it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| cyc_strobe | input | 1 | One-clock pulse per switching cycle |
| vcc_ovp | input | 1 | Supply overvoltage comparator |
| fovp_hit | input | 1 | Fast output overvoltage comparator, sampled on `cyc_strobe` |
| ocp_stop | input | 1 | Emergency overcurrent stop request |
| vout_code | input | VW | Digitised sensed output voltage |
| vline_code | input | LW | Digitised line voltage, 1 V per LSB |
| temp_code | input | TW | Digitised die temperature, 1 degree per LSB |
| sw_en | output | 1 | Switching allowed |
| slow_ovp | output | 1 | Request to stretch the switching period |
| fault_cause | output | 3 | First-fault code |

## Verification
A recovery counter that is off by one shows up as `sw_en` returning one tick early or late. The bench catches this by sampling one tick short of the wait and again at the end of it. A qualification counter that fails to clear appears as a premature stop when partial runs are separated by a good sample. A blanking counter or hysteresis state that is wrong shows as `sw_en` or `slow_ovp` changing while the input sits between its two thresholds. A cause register that is overwritten or not cleared is visible on `fault_cause` within two clocks of the second fault or of the restart.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_SUPPLY_OV = 3'd1,
    FC_FAST_OV   = 3'd2,
    FC_SHORT     = 3'd3,
    FC_OVERCUR   = 3'd4,
    FC_BROWNOUT  = 3'd5,
    FC_LINE_OV   = 3'd6,
    FC_THERMAL   = 3'd7
  } fault_code_e;
endpackage

// File: rtl/persist_count.sv
// Counts consecutive steps on which cond holds; pulses done on the LIMIT-th.
module persist_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic step,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = arm && step && cond && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!arm) begin
      cnt_d = '0;
    end else if (step) begin
      if (!cond || done) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hyst_flag.sv
// Flag set at or above SET_AT, cleared at or below CLR_AT.
module hyst_flag #(
  parameter int W      = 8,
  parameter int SET_AT = 150,
  parameter int CLR_AT = 130
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val,
  output logic         flag
);
  logic flag_d;

  always_comb begin
    if (flag) flag_d = !(val <= W'(CLR_AT));
    else      flag_d = (val >= W'(SET_AT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/recovery_timer.sv
// Reloadable wait of TICKS tick pulses; busy while nonzero.
module recovery_timer #(
  parameter int TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = CW'(TICKS);
    else if (tick && busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int VW          = 9,
  parameter int LW          = 10,
  parameter int TW          = 8,
  parameter int REC_TICKS   = 4000,
  parameter int SHORT_TICKS = 90,
  parameter int BLANK_TICKS = 25,
  parameter int FOVP_CYCLES = 4,
  parameter int VO_SHORT    = 37,
  parameter int VO_ENGAGE   = 230,
  parameter int VO_RELEASE  = 210,
  parameter int BO_ON       = 108,
  parameter int BO_OFF      = 98,
  parameter int LOVP_ON     = 469,
  parameter int LOVP_OFF    = 443,
  parameter int TSD_ON      = 150,
  parameter int TSD_OFF     = 130
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          cyc_strobe,
  input  logic          vcc_ovp,
  input  logic          fovp_hit,
  input  logic          ocp_stop,
  input  logic [VW-1:0] vout_code,
  input  logic [LW-1:0] vline_code,
  input  logic [TW-1:0] temp_code,
  output logic          sw_en,
  output logic          slow_ovp,
  output logic [2:0]    fault_cause
);
  logic fovp_done, short_done, bo_flip, lovp_rel;
  logic bo_ok, bo_ok_d, lovp, lovp_d, hot;
  logic bo_miss, lovp_set, trig, rec_busy, en_d;
  fault_code_e cause_q, cause_d, first_code;

  // Stop-fault qualification
  persist_count #(.LIMIT(FOVP_CYCLES)) u_fovp (
    .clk(clk), .rst_n(rst_n), .arm(sw_en), .step(cyc_strobe),
    .cond(fovp_hit), .done(fovp_done));

  persist_count #(.LIMIT(SHORT_TICKS)) u_short (
    .clk(clk), .rst_n(rst_n), .arm(sw_en), .step(ms_tick),
    .cond(vout_code < VW'(VO_SHORT)), .done(short_done));

  // Line qualification with blanking
  assign bo_miss  = bo_ok ? (vline_code < LW'(BO_OFF)) : (vline_code > LW'(BO_ON));
  assign lovp_set = (vline_code > LW'(LOVP_ON));

  persist_count #(.LIMIT(BLANK_TICKS)) u_bo_blank (
    .clk(clk), .rst_n(rst_n), .arm(1'b1), .step(ms_tick),
    .cond(bo_miss), .done(bo_flip));

  persist_count #(.LIMIT(BLANK_TICKS)) u_lovp_blank (
    .clk(clk), .rst_n(rst_n), .arm(lovp), .step(ms_tick),
    .cond(vline_code < LW'(LOVP_OFF)), .done(lovp_rel));

  // Hysteresis flags
  hyst_flag #(.W(TW), .SET_AT(TSD_ON), .CLR_AT(TSD_OFF)) u_therm (
    .clk(clk), .rst_n(rst_n), .val(temp_code), .flag(hot));

  hyst_flag #(.W(VW), .SET_AT(VO_ENGAGE), .CLR_AT(VO_RELEASE)) u_slow (
    .clk(clk), .rst_n(rst_n), .val(vout_code), .flag(slow_ovp));

  // Shared recovery wait
  assign trig = vcc_ovp || ocp_stop || fovp_done || short_done;

  recovery_timer #(.TICKS(REC_TICKS)) u_rec (
    .clk(clk), .rst_n(rst_n), .load(trig), .tick(ms_tick), .busy(rec_busy));

  // Next-state logic
  always_comb begin
    bo_ok_d = bo_flip ? !bo_ok : bo_ok;
    lovp_d  = lovp_set || (lovp && !lovp_rel);
    en_d    = bo_ok && !lovp && !hot && !rec_busy && !trig;

    if      (vcc_ovp)    first_code = FC_SUPPLY_OV;
    else if (fovp_done)  first_code = FC_FAST_OV;
    else if (short_done) first_code = FC_SHORT;
    else if (ocp_stop)   first_code = FC_OVERCUR;
    else if (!bo_ok)     first_code = FC_BROWNOUT;
    else if (lovp)       first_code = FC_LINE_OV;
    else if (hot)        first_code = FC_THERMAL;
    else                 first_code = FC_NONE;

    if (en_d && !sw_en)        cause_d = FC_NONE;
    else if (cause_q == FC_NONE) cause_d = first_code;
    else                       cause_d = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_ok   <= 1'b0;
      lovp    <= 1'b0;
      sw_en   <= 1'b0;
      cause_q <= FC_NONE;
    end else begin
      bo_ok   <= bo_ok_d;
      lovp    <= lovp_d;
      sw_en   <= en_d;
      cause_q <= cause_d;
    end
  end

  assign fault_cause = cause_q;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int VW         = 9,
  parameter int LW         = 10,
  parameter int TW         = 8,
  parameter int VO_ENGAGE  = 230,
  parameter int VO_RELEASE = 210,
  parameter int LOVP_ON    = 469,
  parameter int TSD_ON     = 150
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vcc_ovp,
  input logic          ocp_stop,
  input logic [VW-1:0] vout_code,
  input logic [LW-1:0] vline_code,
  input logic [TW-1:0] temp_code,
  input logic          sw_en,
  input logic          slow_ovp,
  input logic [2:0]    fault_cause,
  input logic          busy
);
  a_r1_supply_stop: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ovp |=> !sw_en);

  a_r4_overcur_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_stop |=> !sw_en);

  a_r5_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sw_en);

  a_r7_line_block: assert property (@(posedge clk) disable iff (!rst_n)
    (vline_code > LW'(LOVP_ON)) |=> ##1 !sw_en);

  a_r8_thermal_block: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TW'(TSD_ON)) |=> ##1 !sw_en);

  a_r9_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_ovp && vout_code > VW'(VO_RELEASE)) |=> slow_ovp);

  a_r9_slow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_ovp && vout_code < VW'(VO_ENGAGE)) |=> !slow_ovp);

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != 3'd0 && !sw_en) |=>
      ((fault_cause == $past(fault_cause)) || (sw_en && fault_cause == 3'd0)));
endmodule

bind fault_supervisor fsup_checker #(
  .VW(VW), .LW(LW), .TW(TW), .VO_ENGAGE(VO_ENGAGE), .VO_RELEASE(VO_RELEASE),
  .LOVP_ON(LOVP_ON), .TSD_ON(TSD_ON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_ovp(vcc_ovp), .ocp_stop(ocp_stop),
  .vout_code(vout_code), .vline_code(vline_code), .temp_code(temp_code),
  .sw_en(sw_en), .slow_ovp(slow_ovp), .fault_cause(fault_cause), .busy(rec_busy)
);

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
  localparam int REC   = 8;
  localparam int SHORT = 6;
  localparam int BLANK = 5;
  localparam int FOVP  = 4;

  logic       clk = 1'b0;
  logic       rst_n, ms_tick, cyc_strobe, vcc_ovp, fovp_hit, ocp_stop;
  logic [8:0] vout_code;
  logic [9:0] vline_code;
  logic [7:0] temp_code;
  logic       sw_en, slow_ovp;
  logic [2:0] fault_cause;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fault_supervisor #(
    .REC_TICKS(REC), .SHORT_TICKS(SHORT), .BLANK_TICKS(BLANK), .FOVP_CYCLES(FOVP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cyc_strobe(cyc_strobe),
    .vcc_ovp(vcc_ovp), .fovp_hit(fovp_hit), .ocp_stop(ocp_stop),
    .vout_code(vout_code), .vline_code(vline_code), .temp_code(temp_code),
    .sw_en(sw_en), .slow_ovp(slow_ovp), .fault_cause(fault_cause));

  // slow-OVP vectors: {vout, expected slow_ovp}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {9'd200, 1'b0}, {9'd229, 1'b0}, {9'd230, 1'b1}, {9'd215, 1'b1},
    {9'd211, 1'b1}, {9'd210, 1'b0}, {9'd225, 1'b0}, {9'd240, 1'b1},
    {9'd100, 1'b0}, {9'd200, 1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cyc_strobe = 1'b1;
      @(negedge clk) cyc_strobe = 1'b0;
    end
  endtask

  task automatic pulse_vcc();
    @(negedge clk) vcc_ovp = 1'b1;
    @(negedge clk) vcc_ovp = 1'b0;
  endtask

  task automatic pulse_ocp();
    @(negedge clk) ocp_stop = 1'b1;
    @(negedge clk) ocp_stop = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; cyc_strobe = 1'b0; vcc_ovp = 1'b0;
    fovp_hit = 1'b0; ocp_stop = 1'b0; vout_code = 9'd200;
    vline_code = 10'd300; temp_code = 8'd25;
    settle(4);
    chk("R6 reset sw_en", sw_en, 0);
    chk("R10 reset cause", fault_cause, 0);
    chk("R9 reset slow", slow_ovp, 0);
    rst_n = 1'b1;

    // R6 power-up blanking
    ticks(BLANK - 1); settle(2);
    chk("R6 not yet good", sw_en, 0);
    chk("R10 brownout cause", fault_cause, 5);
    ticks(1); settle(2);
    chk("R6 good after blank", sw_en, 1);
    chk("R10 cleared on restart", fault_cause, 0);

    // R9 vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk) vout_code = VEC[v][9:1];
      settle(2);
      chk("R9 slow_ovp", slow_ovp, int'(VEC[v][0]));
      chk("R9 sw_en untouched", sw_en, 1);
    end

    // R1 supply OVP and recovery length
    pulse_vcc(); settle(1);
    chk("R1 stop", sw_en, 0);
    chk("R10 supply cause", fault_cause, 1);
    ticks(REC - 1); settle(2);
    chk("R1 still waiting", sw_en, 0);
    ticks(1); settle(2);
    chk("R1 restart", sw_en, 1);

    // R5 new fault reloads wait; R10 first kept
    pulse_vcc(); ticks(4);
    pulse_ocp(); settle(1);
    chk("R4 stop during wait", sw_en, 0);
    chk("R10 first cause kept", fault_cause, 1);
    ticks(REC - 1); settle(2);
    chk("R5 wait reloaded", sw_en, 0);
    ticks(1); settle(2);
    chk("R5 restart", sw_en, 1);
    chk("R10 clear", fault_cause, 0);

    // R4 overcurrent alone
    pulse_ocp(); settle(1);
    chk("R4 stop", sw_en, 0);
    chk("R10 overcur cause", fault_cause, 4);
    ticks(REC); settle(2);
    chk("R4 restart", sw_en, 1);

    // R2 fast OVP confirmation
    fovp_hit = 1'b1; strobes(FOVP - 1); settle(1);
    chk("R2 below count", sw_en, 1);
    fovp_hit = 1'b0; strobes(1);
    fovp_hit = 1'b1; strobes(FOVP - 1); settle(1);
    chk("R2 count restarted", sw_en, 1);
    strobes(1); settle(1);
    chk("R2 confirmed", sw_en, 0);
    chk("R10 fast cause", fault_cause, 2);
    fovp_hit = 1'b0;
    ticks(REC); settle(2);
    chk("R2 restart", sw_en, 1);

    // R3 output short
    vout_code = 9'd30; ticks(SHORT / 2);
    vout_code = 9'd200; ticks(1);
    vout_code = 9'd30; ticks(SHORT - SHORT / 2); settle(2);
    chk("R3 broken run ignored", sw_en, 1);
    ticks(SHORT / 2 - 1); settle(1);
    chk("R3 one short of limit", sw_en, 1);
    ticks(1); settle(1);
    chk("R3 short confirmed", sw_en, 0);
    chk("R10 short cause", fault_cause, 3);
    vout_code = 9'd200;
    ticks(REC); settle(2);
    chk("R3 restart", sw_en, 1);

    // R6 brown-out hysteresis and blanking
    vline_code = 10'd100; ticks(BLANK + 2); settle(2);
    chk("R6 between thresholds", sw_en, 1);
    vline_code = 10'd97; ticks(BLANK - 1); settle(2);
    chk("R6 drop blanked", sw_en, 1);
    ticks(1); settle(2);
    chk("R6 brown-out", sw_en, 0);
    chk("R10 brownout cause", fault_cause, 5);
    vline_code = 10'd300; ticks(BLANK); settle(2);
    chk("R6 recover", sw_en, 1);

    // R7 line OVP
    @(negedge clk) vline_code = 10'd470; settle(2);
    chk("R7 set immediate", sw_en, 0);
    chk("R10 line cause", fault_cause, 6);
    vline_code = 10'd450; ticks(BLANK + 2); settle(2);
    chk("R7 hold between", sw_en, 0);
    vline_code = 10'd400; ticks(BLANK - 1); settle(2);
    chk("R7 release blanked", sw_en, 0);
    ticks(1); settle(2);
    chk("R7 released", sw_en, 1);

    // R8 thermal
    @(negedge clk) temp_code = 8'd150; settle(2);
    chk("R8 shutdown", sw_en, 0);
    chk("R10 thermal cause", fault_cause, 7);
    temp_code = 8'd140; settle(3);
    chk("R8 hysteresis hold", sw_en, 0);
    temp_code = 8'd130; settle(3);
    chk("R8 released", sw_en, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule